// File: doc/BRIEF.md
# Configurable-length SPI controller

This block is a register-mapped SPI peripheral that acts either as the bus master or as a selected slave. Software programs a control word that sets the role, the bit order, the frame length and the interrupt enable. It then moves frame data through a data register. In master role, a write to the data register launches a frame on a self-generated SCK. In slave role, the data register holds the word that is shifted back while an external master clocks the block.

The SPI timing is fixed to one mode. SCK idles low, each data line is sampled on the rising SCK edge, and the driving side changes its line on the falling edge. Three status flags record frame completion, a mode fault (another device pulling the select line low while this block is master) and a slave abort (select released in mid-frame). Each flag is cleared by its own access sequence. A registered interrupt level is derived from the completion and mode-fault flags.

The shift engine is a five-state machine:
- `ST_IDLE`: waits. It leaves to `ST_M_LOW` on a master data write, or to `ST_S_ACTIVE` when it is selected as a slave.
- `ST_M_LOW`: holds SCK low for one half period, then moves to `ST_M_HIGH` (SCK rising, input sampled).
- `ST_M_HIGH`: holds SCK high for one half period. After the last bit it returns to `ST_IDLE`; otherwise it shifts and goes back to `ST_M_LOW`.
- `ST_S_ACTIVE`: samples on each rising SCK and shifts on each falling SCK. Completion moves it to `ST_S_HOLD`. Deselection moves it to `ST_IDLE`, raising an abort if at least one bit was taken.
- `ST_S_HOLD`: waits for deselection, then returns to `ST_IDLE`.

A mode fault forces any state to `ST_IDLE`.

Top module: `spi_frame_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0, `irq` is low, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: Setting control bit 5 selects master role. In master role a write to the data register (address 2) starts a frame. SCK is driven with a half period of max(div/2,1) clocks, where div is held in register 3. The first data bit is presented before the first rising SCK edge.
- R3: Control bit 6 at 0 shifts the most significant frame bit first. At 1 it shifts bit 0 first. Received bits are reassembled in the same order, so a looped-back word reads back unchanged.
- R4: With control bit 2 at 0, frames are 8 bits regardless of the length field. With bit 2 at 1, the field in bits 11:8 selects the length: codes 1000 to 1111 give 8 to 15 bits, 0000 gives 16 bits, and codes 0001 to 0111 give 8 bits.
- R5: Status bit 7 sets when a frame ends. An access to the data register alone leaves it set. A status read while it is set, followed by any data register access, clears it.
- R6: In master role, a low level on `ssel_n` sets status bit 4 and clears control bit 5. A control write alone leaves bit 4 set. A status read while it is set, followed by a control write, clears it.
- R7: In slave role, `ssel_n` rising after at least one bit and before the last bit sets status bit 3. The next status read clears it.
- R8: In slave role with `ssel_n` low, the block samples `mosi_in` on rising `sck_in` and drives `miso_out` (with `miso_oe` high) from the data register word. The received word is readable at address 2 after the frame.
- R9: `irq` is a registered level equal to control bit 7 AND (status bit 7 OR status bit 4), one clock after the flags.
- R10: Control bits 15:12 and 4:3 and 1:0, and status bits 6:5 and 2:0, always read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe (one clock per access) |
| reg_wr | input | 1 | Write strobe (one clock per access) |
| reg_rdata | output | 16 | Read data for the selected register |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| mosi_in | input | 1 | Serial data in (slave role) |
| mosi_out | output | 1 | Serial data out (master role) |
| mosi_oe | output | 1 | Drive enable for mosi_out |
| miso_in | input | 1 | Serial data in (master role) |
| miso_out | output | 1 | Serial data out (slave role) |
| miso_oe | output | 1 | Drive enable for miso_out |
| ssel_n | input | 1 | Active-low select / fault sense |
| irq | output | 1 | Interrupt level |

## Verification
The hardest cases to reach are the two-step flag clears. Each one needs a single ordered pair of accesses, and the wrong first access must be shown to leave the flag set. For the completion flag, the stimulus waits a fixed time instead of polling status. It then accesses data first, reads status, and only then accesses data again. For the mode fault, the bench pulls `ssel_n` low while in master role, releases it, and writes control before any status read. A slave-abort case drives a three-bit partial frame from the bench's own SCK before releasing the select.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_ACTIVE,
        ST_S_HOLD
    } eng_state_t;

    typedef struct packed {
        logic [3:0] len_code;
        logic       irq_en;
        logic       lsb_first;
        logic       master;
        logic       len_en;
    } ctrl_t;

    // frame length in bits from the enable bit and the 4-bit code
    function automatic logic [4:0] frame_bits(input logic len_en, input logic [3:0] code);
        if (!len_en)
            return 5'd8;
        else if (code == 4'd0)
            return 5'd16;
        else if (code[3])
            return {1'b0, code};
        else
            return 5'd8;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] half_lim;
    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        half_lim = div_val >> 1;
        if (half_lim == '0) half_lim = DIV_W'(1);
    end

    assign tick = run && (cnt_q == half_lim - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_frame_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              start,
    input  logic              kill,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ssel_s,
    input  logic              miso_raw,
    output logic              run,
    output logic              sck_gen,
    output logic              out_bit,
    output logic              busy,
    output logic              selected,
    output logic              done,
    output logic              abort,
    output logic [DATA_W-1:0] rx_word
);

    localparam int IDX_W = $clog2(DATA_W);

    eng_state_t        state_q, nxt;
    logic [DATA_W-1:0] sh_q, rx_q, sh_adv;
    logic [CNT_W-1:0]  cnt_q;
    logic              sck_q, sck_d;
    logic [IDX_W-1:0]  top_idx;
    logic              sck_rise, sck_fall, slave_last;

    assign top_idx    = IDX_W'(nbits - CNT_W'(1));
    assign sck_rise   = sck_s & ~sck_d;
    assign sck_fall   = ~sck_s & sck_d;
    assign slave_last = (cnt_q == nbits - CNT_W'(1));
    assign sh_adv     = lsb_first ? (sh_q >> 1) : (sh_q << 1);

    function automatic logic [DATA_W-1:0] rx_put(input logic [DATA_W-1:0] cur, input logic b,
                                                 input logic lsbf, input logic [IDX_W-1:0] idx);
        if (lsbf) return (cur >> 1) | (DATA_W'(b) << idx);
        else      return {cur[DATA_W-2:0], b};
    endfunction

    // next-state decision
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kill)                      nxt = ST_IDLE;
                else if (master && start)      nxt = ST_M_LOW;
                else if (!master && !ssel_s)   nxt = ST_S_ACTIVE;
            end
            ST_M_LOW: begin
                if (kill)      nxt = ST_IDLE;
                else if (tick) nxt = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (kill)      nxt = ST_IDLE;
                else if (tick) nxt = (cnt_q == nbits) ? ST_IDLE : ST_M_LOW;
            end
            ST_S_ACTIVE: begin
                if (master || kill || ssel_s)    nxt = ST_IDLE;
                else if (sck_rise && slave_last) nxt = ST_S_HOLD;
            end
            ST_S_HOLD: begin
                if (master || ssel_s) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            rx_q    <= '0;
            cnt_q   <= '0;
            sck_q   <= 1'b0;
            sck_d   <= 1'b0;
            done    <= 1'b0;
            abort   <= 1'b0;
            rx_word <= '0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            sck_d <= sck_s;
            unique case (state_q)
                ST_IDLE: begin
                    sck_q <= 1'b0;
                    if (nxt == ST_M_LOW || nxt == ST_S_ACTIVE) begin
                        sh_q  <= tx_word;
                        rx_q  <= '0;
                        cnt_q <= '0;
                    end
                end
                ST_M_LOW: begin
                    if (kill) sck_q <= 1'b0;
                    else if (tick) begin
                        sck_q <= 1'b1;
                        rx_q  <= rx_put(rx_q, miso_raw, lsb_first, top_idx);
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_M_HIGH: begin
                    if (kill) sck_q <= 1'b0;
                    else if (tick) begin
                        sck_q <= 1'b0;
                        if (cnt_q == nbits) begin
                            done    <= 1'b1;
                            rx_word <= rx_q;
                        end else begin
                            sh_q <= sh_adv;
                        end
                    end
                end
                ST_S_ACTIVE: begin
                    if (master || kill) begin
                        cnt_q <= '0;
                    end else if (ssel_s) begin
                        abort <= (cnt_q != '0);
                    end else if (sck_rise) begin
                        rx_q  <= rx_put(rx_q, mosi_s, lsb_first, top_idx);
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (slave_last) begin
                            done    <= 1'b1;
                            rx_word <= rx_put(rx_q, mosi_s, lsb_first, top_idx);
                        end
                    end else if (sck_fall) begin
                        sh_q <= sh_adv;
                    end
                end
                ST_S_HOLD: begin
                    sck_q <= 1'b0;
                end
                default: sck_q <= 1'b0;
            endcase
        end
    end

    assign run      = (state_q == ST_M_LOW) || (state_q == ST_M_HIGH);
    assign busy     = (state_q != ST_IDLE);
    assign selected = (state_q == ST_S_ACTIVE) || (state_q == ST_S_HOLD);
    assign sck_gen  = sck_q;
    assign out_bit  = lsb_first ? sh_q[0] : sh_q[top_idx];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_frame_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int DIV_W   = 8,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    input  logic             reg_wr,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             mosi_in,
    output logic             mosi_out,
    output logic             mosi_oe,
    input  logic             miso_in,
    output logic             miso_out,
    output logic             miso_oe,
    input  logic             ssel_n,
    output logic             irq
);

    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] tx_q, tx_word, rx_word;
    logic              f_spif, f_modf, f_abrt, arm_spif, arm_modf, irq_q;
    logic              sck_s, mosi_s, ssel_s;
    logic              tick, run, sck_gen, out_bit, busy, selected, done, abort;
    logic              ctrl_wr, stat_rd, data_acc, data_wr, start, fault;
    logic [CNT_W-1:0]  nbits;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ssel_n, mosi_in, sck_in}),
        .dout ({ssel_s, mosi_s, sck_s})
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_val(div_q),
        .tick   (tick)
    );

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign stat_rd  = reg_rd && (reg_addr == A_STAT);
    assign data_acc = (reg_rd || reg_wr) && (reg_addr == A_DATA);
    assign data_wr  = reg_wr && (reg_addr == A_DATA);
    assign start    = data_wr && ctrl_q.master && !busy;
    assign fault    = ctrl_q.master && !ssel_s;
    assign tx_word  = start ? reg_wdata[DATA_W-1:0] : tx_q;
    assign nbits    = frame_bits(ctrl_q.len_en, ctrl_q.len_code);

    spi_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (ctrl_q.master),
        .lsb_first(ctrl_q.lsb_first),
        .nbits    (nbits),
        .start    (start),
        .kill     (fault),
        .tick     (tick),
        .tx_word  (tx_word),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ssel_s   (ssel_s),
        .miso_raw (miso_in),
        .run      (run),
        .sck_gen  (sck_gen),
        .out_bit  (out_bit),
        .busy     (busy),
        .selected (selected),
        .done     (done),
        .abort    (abort),
        .rx_word  (rx_word)
    );

    // control, divider and transmit registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            tx_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.len_en    <= reg_wdata[2];
                ctrl_q.master    <= reg_wdata[5];
                ctrl_q.lsb_first <= reg_wdata[6];
                ctrl_q.irq_en    <= reg_wdata[7];
                ctrl_q.len_code  <= reg_wdata[11:8];
            end
            if (fault) ctrl_q.master <= 1'b0;
            if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
            if (data_wr && !busy) tx_q <= reg_wdata[DATA_W-1:0];
        end
    end

    // status flags with their clearing sequences
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_spif   <= 1'b0;
            f_modf   <= 1'b0;
            f_abrt   <= 1'b0;
            arm_spif <= 1'b0;
            arm_modf <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (done) begin
                f_spif   <= 1'b1;
                arm_spif <= 1'b0;
            end else if (arm_spif && data_acc) begin
                f_spif   <= 1'b0;
                arm_spif <= 1'b0;
            end else if (stat_rd && f_spif) begin
                arm_spif <= 1'b1;
            end

            if (fault) begin
                f_modf   <= 1'b1;
                arm_modf <= 1'b0;
            end else if (arm_modf && ctrl_wr) begin
                f_modf   <= 1'b0;
                arm_modf <= 1'b0;
            end else if (stat_rd && f_modf) begin
                arm_modf <= 1'b1;
            end

            if (abort)        f_abrt <= 1'b1;
            else if (stat_rd) f_abrt <= 1'b0;

            irq_q <= ctrl_q.irq_en && (f_spif || f_modf);
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL: reg_rdata = REG_W'({4'b0, ctrl_q.len_code, ctrl_q.irq_en, ctrl_q.lsb_first,
                                        ctrl_q.master, 2'b0, ctrl_q.len_en, 2'b0});
            A_STAT: reg_rdata = REG_W'({f_spif, 2'b0, f_modf, f_abrt, 3'b0});
            A_DATA: reg_rdata = REG_W'(rx_word);
            A_DIV:  reg_rdata = REG_W'(div_q);
            default: reg_rdata = '0;
        endcase
    end

    assign sck_out  = sck_gen;
    assign sck_oe   = ctrl_q.master;
    assign mosi_out = out_bit;
    assign mosi_oe  = ctrl_q.master;
    assign miso_out = out_bit;
    assign miso_oe  = selected;
    assign irq      = irq_q;

endmodule

// File: rtl/spi_frame_ctrl_chk.sv
module spi_frame_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_addr,
    input logic        reg_rd,
    input logic [15:0] reg_rdata,
    input logic        sck_out,
    input logic        sck_oe,
    input logic        miso_oe,
    input logic        irq,
    input logic        irq_en,
    input logic        modf_flag,
    input logic        abrt_flag,
    input logic        abort_evt,
    input logic        eng_busy
);

    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sck_out);

    // R6
    fault_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf_flag) |-> !sck_oe);

    // R7
    abort_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && !abort_evt) |=> !abrt_flag);

    // R8
    miso_slave_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !sck_oe);

    // R9
    irq_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && modf_flag) |=> irq);

    // R10
    status_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[2:0] == 3'b0 && reg_rdata[6:5] == 2'b0));

endmodule

bind spi_frame_ctrl spi_frame_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .miso_oe  (miso_oe),
    .irq      (irq),
    .irq_en   (ctrl_q.irq_en),
    .modf_flag(f_modf),
    .abrt_flag(f_abrt),
    .abort_evt(abort),
    .eng_busy (busy)
);

// File: tb/spi_frame_ctrl_test.sv
module spi_frame_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_rdata;
    logic        sck_in = 1'b0, mosi_in = 1'b0, ssel_n = 1'b1, inv_miso = 1'b0;
    logic        sck_out, sck_oe, mosi_out, mosi_oe, miso_in, miso_out, miso_oe, irq;

    int errors = 0, checks = 0;
    int mon_cnt = 0;
    logic [31:0] mon_bits = '0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    assign miso_in = mosi_out ^ inv_miso;

    always @(posedge sck_out) begin
        mon_bits <= {mon_bits[30:0], mosi_out};
        mon_cnt  <= mon_cnt + 1;
    end

    spi_frame_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ssel_n(ssel_n), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] rev(input logic [15:0] v, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = v[n-1-i];
        return r;
    endfunction

    function automatic logic [15:0] lowmask(input logic [31:0] v, input int n);
        return 16'(v & ((32'd1 << n) - 32'd1));
    endfunction

    task automatic master_xfer(input logic [15:0] ctrl, input logic [15:0] tx, input logic inv,
                               output logic [15:0] rx, output logic [31:0] wire_bits, output int nb);
        logic [15:0] st;
        int snap;
        reg_write(2'd0, ctrl);
        inv_miso = inv;
        snap = mon_cnt;
        reg_write(2'd2, tx);
        st = '0;
        for (int k = 0; k < 400 && !st[7]; k++) reg_read(2'd1, st);
        reg_read(2'd2, rx);
        wire_bits = mon_bits;
        nb = mon_cnt - snap;
    endtask

    task automatic slave_frame(input logic [15:0] mval, input int nbits, input int len,
                               output logic [15:0] got);
        got = '0;
        ssel_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi_in = mval[len-1-i];
            repeat (8) @(negedge clk);
            got = {got[14:0], miso_out};
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (8) @(negedge clk);
        ssel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        reg_read(2'd0, d); check("R1 ctrl", d, 0);
        reg_read(2'd1, d); check("R1 status", d, 0);
        check("R1 irq/oe", {irq, sck_oe, mosi_oe, miso_oe}, 0);
    endtask

    task automatic t_master_msb8;
        logic [15:0] rx; logic [31:0] w; int nb;
        reg_write(2'd3, 16'd4);
        master_xfer(16'h0C20, 16'h00A5, 1'b1, rx, w, nb);
        check("R4 len-enable off gives 8", nb, 8);
        check("R3 msb-first wire", lowmask(w, 8), 16'h00A5);
        check("R2 master rx", rx, 16'h005A);
    endtask

    task automatic t_master_lsb12;
        logic [15:0] rx; logic [31:0] w; int nb;
        master_xfer(16'h0C64, 16'h0ABC, 1'b0, rx, w, nb);
        check("R4 code 1100 gives 12", nb, 12);
        check("R3 lsb-first wire", lowmask(w, 12), rev(16'h0ABC, 12));
        check("R3 lsb-first rx", rx, 16'h0ABC);
    endtask

    task automatic t_master_16;
        logic [15:0] rx; logic [31:0] w; int nb;
        master_xfer(16'h0024, 16'h1234, 1'b1, rx, w, nb);
        check("R4 code 0000 gives 16", nb, 16);
        check("R4 wire 16", lowmask(w, 16), 16'h1234);
        check("R2 rx 16", rx, 16'hEDCB);
    endtask

    task automatic t_complete_irq;
        logic [15:0] d;
        reg_write(2'd0, 16'h00A0);
        inv_miso = 1'b0;
        reg_write(2'd2, 16'h000F);
        repeat (100) @(negedge clk);
        check("R9 irq on complete", irq, 1);
        reg_read(2'd2, d);
        reg_read(2'd1, d); check("R5 data access alone keeps flag", d, 16'h0080);
        reg_read(2'd2, d); check("R5 rx", d, 16'h000F);
        reg_read(2'd1, d); check("R5 cleared", d, 0);
        repeat (2) @(negedge clk);
        check("R9 irq drops", irq, 0);
    endtask

    task automatic t_mode_fault;
        logic [15:0] d;
        reg_write(2'd0, 16'h00A0);
        ssel_n = 1'b0;
        repeat (6) @(negedge clk);
        ssel_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_read(2'd0, d); check("R6 role dropped", d, 16'h0080);
        check("R9 irq on fault", irq, 1);
        reg_write(2'd0, 16'h0080);
        reg_read(2'd1, d); check("R6 ctrl write alone keeps flag", d, 16'h0010);
        reg_write(2'd0, 16'h0000);
        reg_read(2'd1, d); check("R6 cleared", d, 0);
        check("R9 irq off", irq, 0);
    endtask

    task automatic t_slave;
        logic [15:0] got, d;
        reg_write(2'd0, 16'h0000);
        reg_write(2'd2, 16'h0096);
        slave_frame(16'h003B, 8, 8, got);
        check("R8 miso word", got, 16'h0096);
        reg_read(2'd1, d); check("R8 slave complete", d, 16'h0080);
        reg_read(2'd2, d); check("R8 slave rx", d, 16'h003B);
    endtask

    task automatic t_abort;
        logic [15:0] got, d;
        reg_write(2'd2, 16'h0000);
        slave_frame(16'h0055, 3, 8, got);
        reg_read(2'd1, d); check("R7 abort set", d, 16'h0008);
        reg_read(2'd1, d); check("R7 abort cleared by read", d, 0);
    endtask

    task automatic t_reserved;
        logic [15:0] d;
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, d); check("R10 ctrl reserved", d, 16'h0FE4);
        reg_write(2'd0, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_master_msb8();
        t_master_lsb12();
        t_master_16();
        t_complete_irq();
        t_mode_fault();
        t_slave();
        t_abort();
        t_reserved();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule